// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves one 32-bit virtual address at a time into a 34-bit physical address by walking a two-level radix table in memory. The requester hands over the virtual address, the kind of access (fetch, load or store), whether the access runs in supervisor or user mode, the make-executable-readable and supervisor-user-access flags, and the physical page number of the root table. The walker then reads 4-byte entries through a simple request/ready memory port, follows a pointer entry from the upper level to the lower one, and checks the leaf against the access rules.

A leaf found at the upper level maps a 4 MiB superpage, and its low page-number bits must be clear. When the leaf still lacks its accessed flag, or its dirty flag on a store, the walker writes the updated entry back to the address it was read from, provided a configuration input allows hardware updates. Every request ends in a one-cycle response carrying either the physical address, the level of the leaf and a global flag, or a typed fault code.

Top module: `pt_walker2`

## Requirements
- R1: `req_ready` is high only while the walker is idle; a request accepted on `req_valid && req_ready` produces exactly one single-cycle `rsp_valid` pulse, after which `req_ready` is high again.
- R2: The first read goes to `(req_root_ppn << 12) + (va[31:22] << 2)`; a read after a pointer entry goes to `(pointer PPN << 12) + (va[21:12] << 2)`; a memory request held without `mem_req_ready` keeps its address and direction.
- R3: A memory error on any entry read, or on the write-back, ends the request with fault code 1 (access).
- R4: An entry with V (bit 0) clear, or with W (bit 2) set and R (bit 1) clear, gives fault code 2; a pointer entry (R, W and X all clear, X at bit 3) at the lower level also gives fault code 2.
- R5: Leaf permission, access code 0 fetch, 1 load, 2 store: fetch needs X, load needs R or (X with `req_mxr`), store needs W; user mode needs U (bit 4) set; supervisor mode may use a U page for load or store only with `req_sum`, never for fetch. A failure gives fault code 3.
- R6: An upper-level leaf whose PPN bits [9:0] are not all zero gives fault code 4.
- R7: On success (fault 0) `rsp_paddr` is `{PPN, va[11:0]}`; for a lower-level leaf PPN is the entry PPN (bits [31:10]) and `rsp_level` is 0; for an upper-level leaf PPN is the entry PPN with bits [9:0] replaced by va[21:12] and `rsp_level` is 1.
- R8: `rsp_global` on success is the OR of the G bits (bit 5) of every entry read during the walk; it is 0 on a fault.
- R9: If the leaf passes all checks but has A (bit 6) clear, or is a store with D (bit 7) clear, and `ad_update_en` is 1, the entry with A set (and D set for a store) is written once to the leaf's own address; no write occurs when nothing needs setting.
- R10: In the R9 case with `ad_update_en` at 0 the request ends with fault code 5 and memory is left unchanged.
- R11: With a memory that accepts at once and answers on the following cycle, `rsp_valid` appears 3 cycles per entry read plus 2 cycles per write-back after the accepting edge.
- R12: After reset `req_ready` is 1 and `mem_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_super | input | 1 | 1 supervisor mode, 0 user mode |
| req_mxr | input | 1 | Loads may use execute-only pages |
| req_sum | input | 1 | Supervisor may load/store user pages |
| req_root_ppn | input | 22 | Page number of the root table |
| ad_update_en | input | 1 | Allow hardware accessed/dirty write-back |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 34 | Entry byte address |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_err | input | 1 | Memory response carries an error |
| mem_rsp_rdata | input | 32 | Entry value read |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 34 | Physical address (valid with fault 0) |
| rsp_level | output | 1 | Level of the leaf |
| rsp_global | output | 1 | Sticky global flag |
| rsp_fault | output | 3 | 0 ok, 1 access, 2 invalid, 3 permission, 4 misaligned, 5 update blocked |

## Verification
Each entry read costs three cycles (request, response capture, evaluation) and each write-back two, so with the bench memory answering one cycle after acceptance the result is due 3×reads + 2×writes cycles after the accepting edge. The bench counts falling edges from the accept to the first sighting of `rsp_valid`, compares that count with the figure derived from the expected walk depth, and only then samples the result fields; it checks on the next falling edge that the pulse has gone. Memory addresses are sampled on the falling edge of the cycle in which the request is handed over, and one run with a stalled memory port drops the cycle count check while keeping every value check.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int PG_BITS   = 12;
  localparam int LVL_BITS  = 10;
  localparam int LEVELS    = 2;
  localparam int PTE_W     = 32;
  localparam int PTE_LOG   = $clog2(PTE_W / 8);
  localparam int PPN_W     = 22;
  localparam int PA_W      = PPN_W + PG_BITS;
  localparam int VPN_W     = VA_W - PG_BITS;
  localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int FLT_W     = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [FLT_W-1:0] {
    FLT_NONE     = 3'd0,
    FLT_ACCESS   = 3'd1,
    FLT_INVALID  = 3'd2,
    FLT_PERM     = 3'd3,
    FLT_MISALIGN = 3'd4,
    FLT_ADUPD    = 3'd5
  } fault_e;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       rsv;
    logic             d;
    logic             a;
    logic             g;
    logic             u;
    logic             x;
    logic             w;
    logic             r;
    logic             v;
  } pte_t;

  // Entry is unusable: not valid, or writable without being readable.
  function automatic logic ent_is_bad(input pte_t p);
    return !p.v || (p.w && !p.r);
  endfunction

  // Entry points at the next table rather than a page.
  function automatic logic ent_is_ptr(input pte_t p);
    return !p.r && !p.w && !p.x;
  endfunction

  // Page-number bits that a leaf at the given level takes from the VPN.
  function automatic logic [PPN_W-1:0] span_mask(input int unsigned lvl);
    return (PPN_W'(1) << (lvl * LVL_BITS)) - PPN_W'(1);
  endfunction

  // Byte address of an entry: table base page plus scaled index.
  function automatic logic [PA_W-1:0] slot_addr(input logic [PPN_W-1:0] base,
                                                input logic [LVL_BITS-1:0] idx);
    return {base, {PG_BITS{1'b0}}} + (PA_W'(idx) << PTE_LOG);
  endfunction
endpackage

// File: rtl/ptw_slot_gen.sv
module ptw_slot_gen import ptw_pkg::*; (
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  addr
);
  logic [LVL_BITS-1:0] slice [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_slice
    assign slice[l] = vpn[l*LVL_BITS +: LVL_BITS];
  end

  assign addr = slot_addr(base_ppn, slice[level]);
endmodule

// File: rtl/ptw_rights.sv
module ptw_rights import ptw_pkg::*; (
  input  logic [1:0] acc,
  input  logic       sup,
  input  logic       mxr,
  input  logic       sum,
  input  logic       r,
  input  logic       w,
  input  logic       x,
  input  logic       u,
  output logic       allow
);
  logic mode_data_ok;
  logic mode_exec_ok;

  // User code needs user pages; supervisor data may touch them only with sum.
  assign mode_data_ok = sup ? (!u || sum) : u;
  assign mode_exec_ok = sup ? !u : u;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_FETCH: allow = x && mode_exec_ok;
      ACC_LOAD:  allow = (r || (mxr && x)) && mode_data_ok;
      ACC_STORE: allow = w && mode_data_ok;
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf import ptw_pkg::*; (
  input  pte_t             pte,
  input  logic [LVL_W-1:0] level,
  input  logic [VA_W-1:0]  va,
  input  logic             is_store,
  output logic             misaligned,
  output logic [PA_W-1:0]  paddr,
  output logic             need_ad,
  output pte_t             pte_new
);
  logic [PPN_W-1:0] mask;
  logic [PPN_W-1:0] vpn_ext;
  logic [PPN_W-1:0] ppn_out;

  assign mask       = span_mask(int'(level));
  assign vpn_ext    = PPN_W'(va[VA_W-1:PG_BITS]);
  assign misaligned = |(pte.ppn & mask);
  assign ppn_out    = (pte.ppn & ~mask) | (vpn_ext & mask);
  assign paddr      = {ppn_out, va[PG_BITS-1:0]};
  assign need_ad    = !pte.a || (is_store && !pte.d);

  always_comb begin
    pte_new   = pte;
    pte_new.a = 1'b1;
    pte_new.d = pte.d | is_store;
  end
endmodule

// File: rtl/pt_walker2.sv
module pt_walker2 import ptw_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_super,
  input  logic              req_mxr,
  input  logic              req_sum,
  input  logic [PPN_W-1:0]  req_root_ppn,
  input  logic              ad_update_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic [PTE_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [PTE_W-1:0]  mem_rsp_rdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [LVL_W-1:0]  rsp_level,
  output logic              rsp_global,
  output logic [FLT_W-1:0]  rsp_fault
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_EVAL, S_WR_REQ, S_WR_WAIT, S_DONE
  } st_e;

  st_e              st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             sup_q;
  logic             mxr_q;
  logic             sum_q;
  logic [PPN_W-1:0] base_q;
  logic [LVL_W-1:0] lvl_q;
  logic             glob_q;
  pte_t             pte_q;
  logic             rd_err_q;
  fault_e           fault_q;
  logic [PA_W-1:0]  pa_q;
  pte_t             wdata_q;

  // Named evaluation events, also watched by the checker.
  logic   ev_on;
  logic   ent_bad;
  logic   ent_ptr;
  logic   perm_ok;
  logic   leaf_misal;
  logic   leaf_need_ad;
  logic   ptr_follow;
  logic   wb_start;
  logic [PA_W-1:0] leaf_pa;
  pte_t   leaf_upd;
  logic [PA_W-1:0] slot;
  fault_e ev_fault;
  st_e    ev_next;
  pte_t   rd_pte;

  assign rd_pte = pte_t'(mem_rsp_rdata);
  assign ev_on  = (st == S_EVAL);

  ptw_slot_gen u_slot (
    .base_ppn (base_q),
    .vpn      (va_q[VA_W-1:PG_BITS]),
    .level    (lvl_q),
    .addr     (slot)
  );

  ptw_rights u_rights (
    .acc   (acc_q),
    .sup   (sup_q),
    .mxr   (mxr_q),
    .sum   (sum_q),
    .r     (pte_q.r),
    .w     (pte_q.w),
    .x     (pte_q.x),
    .u     (pte_q.u),
    .allow (perm_ok)
  );

  ptw_leaf u_leaf (
    .pte        (pte_q),
    .level      (lvl_q),
    .va         (va_q),
    .is_store   (acc_q == ACC_STORE),
    .misaligned (leaf_misal),
    .paddr      (leaf_pa),
    .need_ad    (leaf_need_ad),
    .pte_new    (leaf_upd)
  );

  assign ent_bad = ent_is_bad(pte_q);
  assign ent_ptr = ent_is_ptr(pte_q);

  // Decision order: memory error, bad entry, pointer, rights, alignment, A/D.
  always_comb begin
    ev_fault = FLT_NONE;
    ev_next  = S_DONE;
    if (rd_err_q) begin
      ev_fault = FLT_ACCESS;
    end else if (ent_bad) begin
      ev_fault = FLT_INVALID;
    end else if (ent_ptr) begin
      if (lvl_q == '0) ev_fault = FLT_INVALID;
      else             ev_next  = S_RD_REQ;
    end else if (!perm_ok) begin
      ev_fault = FLT_PERM;
    end else if (leaf_misal) begin
      ev_fault = FLT_MISALIGN;
    end else if (leaf_need_ad) begin
      if (ad_update_en) ev_next  = S_WR_REQ;
      else              ev_fault = FLT_ADUPD;
    end
  end

  assign ptr_follow = ev_on && (ev_next == S_RD_REQ);
  assign wb_start   = ev_on && (ev_next == S_WR_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      va_q     <= '0;
      acc_q    <= '0;
      sup_q    <= 1'b0;
      mxr_q    <= 1'b0;
      sum_q    <= 1'b0;
      base_q   <= '0;
      lvl_q    <= '0;
      glob_q   <= 1'b0;
      pte_q    <= '0;
      rd_err_q <= 1'b0;
      fault_q  <= FLT_NONE;
      pa_q     <= '0;
      wdata_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr;
            acc_q   <= req_acc;
            sup_q   <= req_super;
            mxr_q   <= req_mxr;
            sum_q   <= req_sum;
            base_q  <= req_root_ppn;
            lvl_q   <= LVL_W'(LEVELS - 1);
            glob_q  <= 1'b0;
            fault_q <= FLT_NONE;
            st      <= S_RD_REQ;
          end
        end
        S_RD_REQ: begin
          if (mem_req_ready) st <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (mem_rsp_valid) begin
            pte_q    <= rd_pte;
            rd_err_q <= mem_rsp_err;
            if (!mem_rsp_err) glob_q <= glob_q | rd_pte.g;
            st       <= S_EVAL;
          end
        end
        S_EVAL: begin
          fault_q <= ev_fault;
          pa_q    <= leaf_pa;
          wdata_q <= leaf_upd;
          if (ptr_follow) begin
            base_q <= pte_q.ppn;
            lvl_q  <= lvl_q - LVL_W'(1);
          end
          st <= ev_next;
        end
        S_WR_REQ: begin
          if (mem_req_ready) st <= S_WR_WAIT;
        end
        S_WR_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) fault_q <= FLT_ACCESS;
            st <= S_DONE;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD_REQ) || (st == S_WR_REQ);
  assign mem_req_write = (st == S_WR_REQ);
  assign mem_req_addr  = slot;
  assign mem_req_wdata = wdata_q;
  assign rsp_valid     = (st == S_DONE);
  assign rsp_paddr     = pa_q;
  assign rsp_level     = lvl_q;
  assign rsp_global    = glob_q && (fault_q == FLT_NONE);
  assign rsp_fault     = fault_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker import ptw_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              ad_update_en,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [PA_W-1:0]   mem_req_addr,
  input logic [PTE_W-1:0]  mem_req_wdata,
  input logic              rsp_valid,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              rsp_global,
  input logic [FLT_W-1:0]  rsp_fault,
  input logic [VA_W-1:0]   va_q,
  input logic [LVL_W-1:0]  lvl_q,
  input logic              ptr_follow,
  input logic              wb_start
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R1

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R1

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R2

  AST_PTR_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_follow |-> lvl_q != '0); // R4

  AST_WB_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_start |-> ad_update_en); // R10

  AST_WB_ABIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[6]); // R9

  AST_PAGE_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == '0 |-> rsp_paddr[PG_BITS-1:0] == va_q[PG_BITS-1:0]); // R7

  AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault <= FLT_W'(5)); // R3

  AST_GLOBAL_OK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != '0 |-> !rsp_global); // R8
endmodule

bind pt_walker2 ptw_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .ad_update_en  (ad_update_en),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .rsp_valid     (rsp_valid),
  .rsp_paddr     (rsp_paddr),
  .rsp_global    (rsp_global),
  .rsp_fault     (rsp_fault),
  .va_q          (va_q),
  .lvl_q         (lvl_q),
  .ptr_follow    (ptr_follow),
  .wb_start      (wb_start)
);

// File: tb/tb_pt_walker2.sv
module tb_pt_walker2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_super = 1'b0;
  logic        req_mxr = 1'b0;
  logic        req_sum = 1'b0;
  logic [21:0] req_root_ppn = 22'h1;
  logic        ad_update_en = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        mem_req_write;
  logic [33:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic        mem_rsp_err;
  logic [31:0] mem_rsp_rdata;
  logic        rsp_valid;
  logic [33:0] rsp_paddr;
  logic        rsp_level;
  logic        rsp_global;
  logic [2:0]  rsp_fault;

  int n_checks = 0;
  int n_errors = 0;
  int wr_total;
  int wd_cnt = 0;

  always #10 clk = ~clk;

  pt_walker2 dut (.*);

  // Behavioural memory: 16 KiB, words above it error, page 3 refuses writes.
  logic [31:0] mem [4096];

  function automatic logic [31:0] pe(input logic [21:0] ppn, input logic [7:0] f);
    return {ppn, 2'b00, f};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
      mem[12'h400] <= pe(22'h2,      8'h01);
      mem[12'h401] <= pe(22'h3FFC00, 8'hEF);
      mem[12'h402] <= pe(22'h401,    8'hC3);
      mem[12'h404] <= pe(22'h100,    8'h01);
      mem[12'h405] <= pe(22'h3,      8'h21);
      mem[12'h406] <= pe(22'h9,      8'h05);
      mem[12'h407] <= pe(22'h800,    8'h17);
      mem[12'h800] <= pe(22'h12345,  8'hC7);
      mem[12'h801] <= pe(22'h3ABCD,  8'h5B);
      mem[12'h802] <= pe(22'h5,      8'h01);
      mem[12'h803] <= pe(22'h777,    8'h07);
      mem[12'h804] <= pe(22'h11,     8'h43);
      mem[12'h805] <= pe(22'h22,     8'h49);
      mem[12'h806] <= pe(22'h33,     8'h47);
      mem[12'hC00] <= pe(22'h55,     8'hC7);
      mem[12'hC01] <= pe(22'h66,     8'h03);
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      mem_rsp_rdata <= '0;
      wr_total      <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        if (mem_req_write) begin
          wr_total <= wr_total + 1;
          if (mem_req_addr[33:14] != '0 || mem_req_addr[13:12] == 2'd3) begin
            mem_rsp_err <= 1'b1;
          end else begin
            mem_rsp_err <= 1'b0;
            mem[mem_req_addr[13:2]] <= mem_req_wdata;
          end
        end else begin
          mem_rsp_err   <= (mem_req_addr[33:14] != '0);
          mem_rsp_rdata <= mem[mem_req_addr[13:2]];
        end
      end
    end
  end

  always @(posedge clk) begin
    wd_cnt <= wd_cnt + 1;
    if (wd_cnt == 150000) begin
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", n_checks + 1, n_errors + 1);
      $finish;
    end
  end

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic        sup;
    logic        mxr;
    logic        sum;
    logic        aden;
    logic [2:0]  flt;
    logic [33:0] pa;
    logic        lvl;
    logic        glob;
    logic [1:0]  nrd;
    logic        nwr;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{32'h000000AB, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 34'h0123450AB, 1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00001010, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 34'h03ABCD010, 1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00001010, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 34'h03ABCD010, 1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00001010, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3, 34'h0,         1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00001010, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3, 34'h0,         1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00001010, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 34'h03ABCD010, 1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h000000AB, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 34'h0,         1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00401234, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 34'h3FFC01234, 1'b1, 1'b1, 2'd1, 1'b0},
    '{32'h00800000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4, 34'h0,         1'b0, 1'b0, 2'd1, 1'b0},
    '{32'h00C00000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 34'h0,         1'b0, 1'b0, 2'd1, 1'b0},
    '{32'h01000000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 34'h0,         1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h01400040, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 34'h000055040, 1'b0, 1'b1, 2'd2, 1'b0},
    '{32'h01401000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 34'h0,         1'b0, 1'b0, 2'd2, 1'b1},
    '{32'h01800000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 34'h0,         1'b0, 1'b0, 2'd1, 1'b0},
    '{32'h00002000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 34'h0,         1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00004000, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3, 34'h0,         1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00005008, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3, 34'h0,         1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00005008, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 34'h000022008, 1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00005008, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 34'h000022008, 1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00003005, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd5, 34'h0,         1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h00003005, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 34'h000777005, 1'b0, 1'b0, 2'd2, 1'b1},
    '{32'h00003005, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 34'h000777005, 1'b0, 1'b0, 2'd2, 1'b1},
    '{32'h00006000, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 34'h000033000, 1'b0, 1'b0, 2'd2, 1'b1},
    '{32'h00006000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 34'h000033000, 1'b0, 1'b0, 2'd2, 1'b0},
    '{32'h01FFFFFF, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 34'h000BFFFFF, 1'b1, 1'b0, 2'd1, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string fault_tag(input logic [2:0] f);
    case (f)
      3'd0: return "R7 fault";
      3'd1: return "R3 fault";
      3'd2: return "R4 fault";
      3'd3: return "R5 fault";
      3'd4: return "R6 fault";
      default: return "R10 fault";
    endcase
  endfunction

  task automatic run_one(input vec_t v, input bit check_lat);
    int cyc;
    int nrd_seen;
    int wr0;
    bit got;
    logic [33:0] last_rd;
    logic [33:0] exp_addr;
    logic [31:0] root_ent;
    @(negedge clk);
    req_vaddr    = v.va;
    req_acc      = v.acc;
    req_super    = v.sup;
    req_mxr      = v.mxr;
    req_sum      = v.sum;
    ad_update_en = v.aden;
    req_valid    = 1'b1;
    chk("R1 ready while idle", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after accept", 64'(req_ready), 64'd0);
    wr0 = wr_total;
    cyc = 0;
    nrd_seen = 0;
    got = 1'b0;
    last_rd = '0;
    while (cyc < 200 && !got) begin
      if (mem_req_valid && mem_req_ready && !mem_req_write) begin
        if (nrd_seen == 0) begin
          exp_addr = 34'h1000 + {22'd0, v.va[31:22], 2'b00};
        end else begin
          root_ent = mem[12'h400 + 12'(v.va[31:22])];
          exp_addr = {root_ent[31:10], 12'h000} + {22'd0, v.va[21:12], 2'b00};
        end
        chk("R2 entry address", 64'(mem_req_addr), 64'(exp_addr));
        last_rd = mem_req_addr;
        nrd_seen++;
      end
      if (mem_req_valid && mem_req_ready && mem_req_write)
        chk("R9 write-back address", 64'(mem_req_addr), 64'(last_rd));
      @(negedge clk);
      cyc++;
      if (rsp_valid) got = 1'b1;
    end
    if (!got) begin
      chk("R1 response timeout", 64'd0, 64'd1);
      return;
    end
    if (check_lat)
      chk("R11 latency", 64'(cyc), 64'(3 * int'(v.nrd) + 2 * int'(v.nwr)));
    chk(fault_tag(v.flt), 64'(rsp_fault), 64'(v.flt));
    if (v.flt == 3'd0) begin
      chk("R7 paddr", 64'(rsp_paddr), 64'(v.pa));
      chk("R7 level", 64'(rsp_level), 64'(v.lvl));
      chk("R8 global", 64'(rsp_global), 64'(v.glob));
    end else begin
      chk("R8 global on fault", 64'(rsp_global), 64'd0);
    end
    chk(v.flt == 3'd5 ? "R10 no write" : "R9 write count",
        64'(wr_total - wr0), 64'(v.nwr));
    @(negedge clk);
    chk("R1 single pulse", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 ready after reset", 64'(req_ready), 64'd1);
    chk("R12 no memory request", 64'(mem_req_valid), 64'd0);
    chk("R12 no response", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_one(VECS[i], 1'b1);
      if (i == 19)
        chk("R10 entry untouched", 64'(mem[12'h803]), 64'(pe(22'h777, 8'h07)));
    end

    chk("R9 A and D written", 64'(mem[12'h803]), 64'(pe(22'h777, 8'hC7)));
    chk("R9 D written", 64'(mem[12'h806]), 64'(pe(22'h33, 8'hC7)));
    chk("R9 superpage A and D", 64'(mem[12'h407]), 64'(pe(22'h800, 8'hD7)));
    chk("R3 failed write leaves entry", 64'(mem[12'hC01]), 64'(pe(22'h66, 8'h03)));

    // Stalled memory port: values must still be right (R2 hold).
    mem_req_ready = 1'b0;
    fork
      run_one(VECS[0], 1'b0);
      begin
        repeat (4) @(posedge clk);
        #2 mem_req_ready = 1'b1;
      end
    join

    // Same superpage with the sticky G coming only from the leaf itself.
    run_one(VECS[7], 1'b1);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule